// File: doc/BRIEF.md
# Indirect Host Register Port

This block is the host-facing register port of a small peripheral controller. The host sees only two byte locations. A write to location 0 loads an internal register pointer, and a read of location 0 returns an auxiliary status byte with no side effect. Location 1 reads or writes the register that the pointer selects, and every access to location 1 moves the pointer on by one. Because of this, a multi-byte command block or the 24-bit transfer count can be streamed with a single pointer write.

Behind the port are 26 byte registers. The command register starts the external command engine. A small controller tracks command progress with three states. **IDLE**: no command is running. **LATCH**: command in progress, held for `CIP_CYCLES` cycles after acceptance. **RUN**: busy, but the command register is writable again. The transitions are:

- IDLE→LATCH when a command is accepted.
- LATCH→RUN when the latch window expires.
- RUN→LATCH when a new command is accepted.
- LATCH→IDLE or RUN→IDLE on `eng_done`.

While a command is running, most registers are locked. A command that arrives during LATCH is dropped and flagged. Bus signalling and data movement are outside the block and appear only as the `eng_done`, `eng_parity_err` and `eng_buf_ready` inputs.

Top module: `hrp_port`

## Requirements
- R1: After reset, all registers read 0, the pointer is 0, and every flag is clear. The status byte reads 0x00, or 0x01 when `eng_buf_ready` is high.
- R2: The status byte read at location 0 has this layout: bit 7 interrupt pending, bit 6 command ignored, bit 5 busy, bit 4 command in progress, bits 3:2 always 0, bit 1 parity error, bit 0 equal to `eng_buf_ready`. A write to location 0 loads the pointer from `host_wdata[4:0]`.
- R3: Each read or write at location 1 advances the pointer by one, and the pointer wraps from 31 to 0. `xfer_count` is {reg18, reg19, reg20}, so writing the count high byte first from pointer 18 gives the 24-bit value.
- R4: Twelve back-to-back writes starting at pointer 3 fill registers 3 to 14, one byte each clock cycle, and all twelve read back in order.
- R5: When idle, registers 0 to 25 read back the last value written. Pointer values 26 to 31 read 0, and writes to them are ignored.
- R6: A write to register 24 outside LATCH is accepted. The byte is stored verbatim on `cmd_byte` (bit 7 is the single-byte qualifier, bits 6:0 the code). `cmd_start` pulses for one cycle after the write, and busy and in-progress are set on that same cycle.
- R7: In-progress stays set for exactly `CIP_CYCLES` cycles after acceptance. After that, only busy remains set (RUN).
- R8: While busy, location-1 accesses to any register other than 24 and 25 read 0 and do not write, but the pointer still advances. Register 25 remains readable and writable, and register 24 is readable in RUN.
- R9: A command write during LATCH leaves `cmd_byte` unchanged and sets the command-ignored flag.
- R10: A command write in RUN is accepted, re-enters LATCH, and clears the command-ignored flag.
- R11: `eng_done` while busy clears busy and in-progress on the next cycle and sets interrupt pending. `eng_done` while idle has no effect.
- R12: `eng_parity_err` sets the parity flag. A read of register 23 while idle clears both the parity flag and interrupt pending, and `irq` follows interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | Location select: 0 pointer/status, 1 data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| eng_done | input | 1 | Command engine finished |
| eng_parity_err | input | 1 | Parity error seen by the engine |
| eng_buf_ready | input | 1 | Engine data buffer ready |
| cmd_start | output | 1 | One-cycle pulse after a command is accepted |
| cmd_byte | output | 8 | Current command register |
| xfer_count | output | 24 | Transfer count from registers 18..20 |
| irq | output | 1 | Interrupt pending |

## Verification
The pointer is driven in several patterns:
- Single writes, to show it loads.
- Streams of twelve and three accesses, to show it steps on every cycle.
- A start at 31, to show the wrap to register 0.

Locked accesses are interleaved with reads of the command register, which shows the pointer still advanced even though the data was blocked.

Command writes are placed at three points, and each is told apart by `cmd_byte` and the status byte:
- While idle.
- Two cycles into the latch window.
- In the run state.

`eng_done` is applied both while busy and while idle, to separate the two cases.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    localparam int PTR_W = 5;
    localparam int DW    = 8;

    typedef logic [PTR_W-1:0] ridx_t;

    // register numbers whose role the port logic decodes
    localparam ridx_t REG_CNT_HI = 5'd18;
    localparam ridx_t REG_CAUSE  = 5'd23;
    localparam ridx_t REG_CMD    = 5'd24;
    localparam ridx_t REG_DATA   = 5'd25;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_RUN
    } ctl_state_e;
endpackage

// File: rtl/hrp_ptr.sv
module hrp_ptr
    import hrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  ridx_t load_val,
    input  logic  step,
    output ridx_t ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> ptr == $past(ptr) + 1'b1); // R3
endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank
    import hrp_pkg::*;
#(
    parameter int NREG      = 26,
    parameter int CNT_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  ridx_t                   wr_idx,
    input  logic [DW-1:0]           wr_val,
    input  logic                    cmd_ld,
    input  ridx_t                   rd_idx,
    output logic [DW-1:0]           rd_val,
    output logic [DW-1:0]           cmd_q,
    output logic [CNT_BYTES*DW-1:0] count
);
    logic [DW-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(REG_CMD)) begin : g_cmd
            always_ff @(posedge clk) begin
                if (!rst_n)      mem[i] <= '0;
                else if (cmd_ld) mem[i] <= wr_val;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n) mem[i] <= '0;
                else if (wr_en && wr_idx == ridx_t'(i)) mem[i] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == ridx_t'(i)) rd_val = mem[i];
    end

    for (genvar k = 0; k < CNT_BYTES; k++) begin : g_cnt
        assign count[(CNT_BYTES-1-k)*DW +: DW] = mem[int'(REG_CNT_HI) + k];
    end

    assign cmd_q = mem[int'(REG_CMD)];
endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
    import hrp_pkg::*;
#(
    parameter int CIP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic done,
    input  logic stat_rd,
    input  logic par_set,
    output logic accept,
    output logic busy,
    output logic cip,
    output logic lci,
    output logic irq_q,
    output logic perr,
    output logic start_q
);
    localparam int CW = $clog2(CIP_CYCLES + 1);

    ctl_state_e    state, state_nx;
    logic [CW-1:0] cnt;

    // outputs decoded from the state
    always_comb begin
        busy   = (state != ST_IDLE);
        cip    = (state == ST_LATCH);
        accept = cmd_wr && !cip;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_LATCH;
            ST_LATCH: if (done) state_nx = ST_IDLE;
                      else if (cnt == '0) state_nx = ST_RUN;
            ST_RUN:   if (accept) state_nx = ST_LATCH;
                      else if (done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; lci <= 1'b0; irq_q <= 1'b0; perr <= 1'b0; start_q <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept) cnt <= CW'(CIP_CYCLES - 1);
            else if (cip && cnt != '0) cnt <= cnt - 1'b1;
            if (accept) lci <= 1'b0;
            else if (cmd_wr) lci <= 1'b1;
            if (done && busy) irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
            if (par_set) perr <= 1'b1;
            else if (stat_rd) perr <= 1'b0;
        end
    end

    // checker: consecutive cycles in progress
    logic [CW:0] cip_age;
    always_ff @(posedge clk) begin
        if (!rst_n)   cip_age <= '0;
        else if (cip) cip_age <= cip_age + 1'b1;
        else          cip_age <= '0;
    end

    AST_ACCEPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cip && busy && start_q); // R6
    AST_CIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cip |-> cip_age < (CW+1)'(CIP_CYCLES)); // R7
    AST_BLOCKED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cip |=> lci); // R9
    AST_RUN_CLEARS_LCI: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy && !cip |=> !lci && cip); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && busy && !accept |=> !busy && irq_q); // R11
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done && !busy && !cmd_wr && !stat_rd |=> !busy && $stable(irq_q)); // R11
endmodule

// File: rtl/hrp_port.sv
module hrp_port
    import hrp_pkg::*;
#(
    parameter int NREG       = 26,
    parameter int CNT_BYTES  = 3,
    parameter int CIP_CYCLES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_addr,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    input  logic                    eng_done,
    input  logic                    eng_parity_err,
    input  logic                    eng_buf_ready,
    output logic                    cmd_start,
    output logic [7:0]              cmd_byte,
    output logic [CNT_BYTES*8-1:0]  xfer_count,
    output logic                    irq
);
    localparam ridx_t LAST_REG = ridx_t'(NREG - 1);

    ridx_t         ptr;
    logic [DW-1:0] rd_val;
    logic          data_acc, in_map, is_cmd, is_dat, reg_open;
    logic          cmd_wr, bank_wr, stat_rd;
    logic          accept, busy, cip, lci, perr;
    logic [DW-1:0] aux;

    always_comb begin
        data_acc = host_addr && (host_rd || host_wr);
        in_map   = ptr <= LAST_REG;
        is_cmd   = ptr == REG_CMD;
        is_dat   = ptr == REG_DATA;
        reg_open = !busy || is_dat || (is_cmd && !cip);
        cmd_wr   = data_acc && host_wr && is_cmd;
        bank_wr  = data_acc && host_wr && in_map && !is_cmd && reg_open;
        stat_rd  = data_acc && host_rd && !host_wr && ptr == REG_CAUSE && reg_open;
        aux      = {irq, lci, busy, cip, 2'b00, perr, eng_buf_ready};
        if (!host_addr)              host_rdata = aux;
        else if (in_map && reg_open) host_rdata = rd_val;
        else                         host_rdata = '0;
    end

    hrp_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (host_wr && !host_addr),
        .load_val (host_wdata[PTR_W-1:0]),
        .step     (data_acc),
        .ptr      (ptr)
    );

    hrp_regbank #(.NREG(NREG), .CNT_BYTES(CNT_BYTES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bank_wr),
        .wr_idx (ptr),
        .wr_val (host_wdata),
        .cmd_ld (accept),
        .rd_idx (ptr),
        .rd_val (rd_val),
        .cmd_q  (cmd_byte),
        .count  (xfer_count)
    );

    hrp_ctrl #(.CIP_CYCLES(CIP_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .done    (eng_done),
        .stat_rd (stat_rd),
        .par_set (eng_parity_err),
        .accept  (accept),
        .busy    (busy),
        .cip     (cip),
        .lci     (lci),
        .irq_q   (irq),
        .perr    (perr),
        .start_q (cmd_start)
    );

    AST_AUX_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_addr |-> host_rdata[3:2] == 2'b00); // R2
    AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr && busy && !is_dat && !is_cmd |-> host_rdata == 8'h00); // R8
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cip |=> $stable(cmd_byte)); // R9
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr && !in_map |-> host_rdata == 8'h00); // R5
endmodule

// File: tb/tb_hrp_port.sv
module tb_hrp_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        eng_done = 1'b0, eng_parity_err = 1'b0, eng_buf_ready = 1'b0;
    logic        cmd_start;
    logic [7:0]  cmd_byte;
    logic [23:0] xfer_count;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hrp_port dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_done(eng_done), .eng_parity_err(eng_parity_err),
        .eng_buf_ready(eng_buf_ready), .cmd_start(cmd_start),
        .cmd_byte(cmd_byte), .xfer_count(xfer_count), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
        eng_done = 1'b0; eng_parity_err = 1'b0;
        #1;
    endtask

    task automatic wr_addr(input logic [7:0] n);  drive(1'b0, 1'b1, 1'b0, n); endtask
    task automatic wr_data(input logic [7:0] v);  drive(1'b1, 1'b1, 1'b0, v); endtask
    task automatic rd_data(output logic [7:0] v); drive(1'b1, 1'b0, 1'b1, 8'h00); v = host_rdata; endtask
    task automatic rd_aux(output logic [7:0] v);  drive(1'b0, 1'b0, 1'b1, 8'h00); v = host_rdata; endtask
    task automatic bus_idle();                    drive(1'b0, 1'b0, 1'b0, 8'h00); endtask

    task automatic pulse_done();
        drive(1'b0, 1'b0, 1'b0, 8'h00); eng_done = 1'b1;
        bus_idle();
    endtask

    function automatic logic [7:0] cdb_val(input int i);
        return 8'(8'h21 + i * 13);
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd_aux(v);           chk("R1 aux after reset", v, 8'h00);
        rd_data(v);          chk("R1 reg0 after reset", v, 8'h00);
        chk("R1 count after reset", xfer_count, 24'h0);
        chk("R1 cmd after reset", cmd_byte, 8'h00);
        eng_buf_ready = 1'b1;
        rd_aux(v);           chk("R2 buf ready bit0", v, 8'h01);
        eng_buf_ready = 1'b0;
    endtask

    task automatic t_count();
        logic [7:0] v;
        wr_addr(8'd18); wr_data(8'h12); wr_data(8'h34); wr_data(8'h56); bus_idle();
        chk("R3 xfer_count high first", xfer_count, 24'h123456);
        wr_addr(8'd18);
        rd_data(v); chk("R3 count hi", v, 8'h12);
        rd_data(v); chk("R3 count mid", v, 8'h34);
        rd_data(v); chk("R3 count lo", v, 8'h56);
    endtask

    task automatic t_cdb();
        logic [7:0] v;
        wr_addr(8'd3);
        for (int i = 0; i < 12; i++) wr_data(cdb_val(i));
        wr_addr(8'd3);
        for (int i = 0; i < 12; i++) begin
            rd_data(v); chk("R4 cdb stream", v, cdb_val(i));
        end
    endtask

    task automatic t_map_edges();
        logic [7:0] v;
        wr_addr(8'd26); wr_data(8'hFF);
        wr_addr(8'd26); rd_data(v); chk("R5 reg26 ignored", v, 8'h00);
        wr_addr(8'd31); rd_data(v); chk("R5 reg31 reads zero", v, 8'h00);
        wr_data(8'h47);
        wr_addr(8'd0);  rd_data(v); chk("R3 wrap 31 to 0", v, 8'h47);
        wr_addr(8'd25); wr_data(8'hC3);
        wr_addr(8'd25); rd_data(v); chk("R5 reg25 readback", v, 8'hC3);
    endtask

    task automatic t_cmd_window();
        logic [7:0] v;
        wr_addr(8'd24); wr_data(8'h85);
        rd_aux(v); chk("R6 busy+cip after accept", v, 8'h30);
        chk("R6 cmd_start pulse", cmd_start, 1'b1);
        chk("R6 cmd stored verbatim", cmd_byte, 8'h85);
        rd_aux(v); chk("R6 cmd_start one cycle", cmd_start, 1'b0);
        chk("R7 cip cycle 2", v, 8'h30);
        rd_aux(v); chk("R7 cip cycle 3", v, 8'h30);
        rd_aux(v); chk("R7 cip cycle 4", v, 8'h30);
        rd_aux(v); chk("R7 run after window", v, 8'h20);
        pulse_done();
        rd_aux(v); chk("R11 done sets irq", v, 8'h80);
        chk("R12 irq pin", irq, 1'b1);
        wr_addr(8'd23); rd_data(v);
        rd_aux(v); chk("R12 cause read clears irq", v, 8'h00);
    endtask

    task automatic t_lockout();
        logic [7:0] v;
        wr_addr(8'd24); wr_data(8'h85);
        wr_addr(8'd24); wr_data(8'h11);
        rd_aux(v); chk("R9 ignored flag", v, 8'h70);
        chk("R9 cmd unchanged", cmd_byte, 8'h85);
        rd_aux(v); rd_aux(v);
        chk("R9 flag held in run", v, 8'h60);
        wr_addr(8'd25); wr_data(8'h5A);
        wr_addr(8'd25); rd_data(v); chk("R8 reg25 open while busy", v, 8'h5A);
        wr_addr(8'd5);  wr_data(8'hAA);
        wr_addr(8'd5);  rd_data(v); chk("R8 locked read zero", v, 8'h00);
        wr_addr(8'd23); rd_data(v);
        rd_data(v); chk("R8 pointer advanced under lock", v, 8'h85);
        wr_addr(8'd24); wr_data(8'h22);
        rd_aux(v); chk("R10 run accept clears flag", v, 8'h30);
        chk("R10 new cmd stored", cmd_byte, 8'h22);
        pulse_done();
        rd_aux(v); chk("R11 done from latch", v, 8'h80);
        wr_addr(8'd23); rd_data(v);
        wr_addr(8'd5);  rd_data(v); chk("R8 locked write ignored", v, cdb_val(2));
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse_done();
        rd_aux(v); chk("R11 done while idle", v, 8'h00);
        drive(1'b0, 1'b0, 1'b0, 8'h00); eng_parity_err = 1'b1;
        bus_idle();
        rd_aux(v); chk("R12 parity flag", v, 8'h02);
        wr_addr(8'd23); rd_data(v);
        rd_aux(v); chk("R12 parity cleared", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_count();
        t_cdb();
        t_map_edges();
        t_cmd_window();
        t_lockout();
        t_flags();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule